// File: doc/BRIEF.md
# Streaming Register Read Port

A memory-mapped slave with one readable data register that is backed by a small internal FIFO. A producer pushes words into the FIFO through a data and valid pair. A bus master drains the FIFO by reading the register. Each completed read returns the oldest word and removes exactly one entry. The next read therefore returns the word that follows.

Every read takes exactly two clock cycles, because the slave inserts one fixed wait state and has no stall output. A DMA-style master can keep its select and read strobes high across many transfers in a row at a constant address. Strobe edges therefore cannot mark where one read ends and the next begins. The block finds transfer boundaries in one of two ways, chosen by a parameter:

- **Start mode:** it uses a one-cycle start-of-transfer pulse from the bus.
- **Counter mode:** it uses an internal one-bit phase counter.

A read of an empty FIFO returns zero and raises a sticky underflow flag. A push into a full FIFO is dropped and raises a sticky overflow flag.

Top module: `stream_reg_port`

## Requirements
- R1: While a read transfer is in progress, `bus_rdata` equals the oldest queued word. When the FIFO is empty, `bus_rdata` is zero.
- R2: Each two-cycle read transfer removes exactly one word, at the clock edge that ends the transfer's second cycle. This holds even when `bus_sel` and `bus_rd` stay high with no gap across back-to-back transfers.
- R3: With `MODE = SRP_MODE_START`, a transfer begins in a cycle where `bus_start`, `bus_rd` and `bus_sel` are all 1, and the cycle after it is the final cycle. With `MODE = SRP_MODE_COUNT`, a phase bit toggles in every cycle that has `bus_rd` and `bus_sel` both high, and a cycle with phase 1 is a final cycle. A start pulse forces the phase to 1 for the next cycle, and the phase returns to 0 whenever either strobe is low.
- R4: No word is removed in any cycle where `bus_rd` or `bus_sel` is 0.
- R5: A cycle with `push_valid` high and the FIFO not full appends `push_data`. Words are read out in the order they were pushed, and a pushed word is readable from the next cycle on.
- R6: A push while the FIFO holds `DEPTH` words is dropped, and `overflow_flag` becomes 1 from the next cycle on.
- R7: A final read cycle on an empty FIFO removes nothing and sets `underflow_flag` from the next cycle on.
- R8: Both flags stay set until a cycle with `flag_clr` high clears them. If a flag's set condition occurs in the same cycle as `flag_clr`, the flag is set.
- R9: While `rst_n` is low at a clock edge, the FIFO is emptied, the boundary state is cleared and both flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Slave select strobe |
| bus_rd | input | 1 | Read strobe |
| bus_start | input | 1 | One-cycle start-of-transfer pulse |
| bus_rdata | output | DATA_W | Read data: the FIFO head, or zero when the FIFO is empty |
| push_valid | input | 1 | Push strobe on the write side |
| push_data | input | DATA_W | Word to push |
| flag_clr | input | 1 | Clears both sticky flags |
| underflow_flag | output | 1 | Sticky: a read found the FIFO empty |
| overflow_flag | output | 1 | Sticky: a push found the FIFO full |

## Verification
The bench builds two copies side by side, one in start mode and one in counter mode. Both use `DATA_W = 16` and `DEPTH = 4`, and both receive the same stimulus, so every back-to-back read pattern is checked against both boundary schemes. The small depth makes a full FIFO and a dropped fifth push reachable in a few cycles. A final scenario holds both strobes high with no start pulse, which separates the two modes: the counter copy drains while the start copy keeps its head.

// File: rtl/srp_pkg.sv
// Package: shared types for the streaming register read port.
// Assumes: nothing beyond IEEE 1800-2017.
package srp_pkg;
    // Selects how transfer boundaries are found.
    typedef enum logic {
        SRP_MODE_START = 1'b0,  // start-of-transfer pulse marks cycle 0
        SRP_MODE_COUNT = 1'b1   // internal phase bit marks cycle 1
    } srp_mode_e;
endpackage

// File: rtl/srp_fifo.sv
// Module: srp_fifo
// Circular-buffer FIFO. The head word is visible combinationally.
// A push into a full FIFO and a pop from an empty FIFO are both ignored.
// Assumes: DEPTH >= 2; push and pop may occur in the same cycle.
module srp_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Write an accepted word into storage.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);                                                    // R6
    AST_POP_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push) |=> (count == $past(count) - 1'b1));          // R2
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == FULL_CNT));                       // R6
endmodule

// File: rtl/srp_xfer_ctrl.sv
// Module: srp_xfer_ctrl
// Finds the final cycle of each two-cycle read transfer.
// The strobes may stay high across back-to-back transfers.
// Assumes: every read lasts exactly two cycles (one fixed wait state).
module srp_xfer_ctrl
    import srp_pkg::*;
#(
    parameter srp_mode_e MODE = SRP_MODE_START
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    input  logic sel,
    input  logic start,
    output logic last_cycle
);
    logic active;
    assign active = rd && sel;

    generate
        if (MODE == SRP_MODE_START) begin : g_start
            logic armed;
            // Remember that a qualified start pulse opened a transfer.
            always_ff @(posedge clk) begin
                if (!rst_n) armed <= 1'b0;
                else        armed <= start && active && !armed;
            end
            assign last_cycle = armed && active;
        end else begin : g_count
            logic phase;
            // Toggle the phase while strobed; a start pulse realigns it.
            always_ff @(posedge clk) begin
                if (!rst_n)      phase <= 1'b0;
                else if (active) phase <= start ? 1'b1 : ~phase;
                else             phase <= 1'b0;
            end
            assign last_cycle = active && phase;
        end
    endgenerate

    AST_NO_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !last_cycle);                                              // R4
    AST_FINAL_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        last_cycle |=> !last_cycle);                                           // R3
endmodule

// File: rtl/stream_reg_port.sv
// Module: stream_reg_port (top)
// One readable register backed by a FIFO. Each completed two-cycle read
// returns the head word and pops it. Sticky flags record underflow and
// overflow.
// Assumes: fixed single wait state, no bursts, no stall output.
module stream_reg_port
    import srp_pkg::*;
#(
    parameter int        DATA_W = 32,
    parameter int        DEPTH  = 16,
    parameter srp_mode_e MODE   = SRP_MODE_START
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_start,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              flag_clr,
    output logic              underflow_flag,
    output logic              overflow_flag
);
    logic              last_cycle;
    logic              fifo_empty, fifo_full;
    logic [DATA_W-1:0] fifo_head;

    srp_xfer_ctrl #(.MODE(MODE)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (bus_rd),
        .sel        (bus_sel),
        .start      (bus_start),
        .last_cycle (last_cycle)
    );

    srp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_valid),
        .push_data (push_data),
        .pop       (last_cycle),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    // Present the head word, or zero when nothing is queued.
    always_comb begin
        bus_rdata = fifo_empty ? '0 : fifo_head;
    end

    // Sticky error flags; a set event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underflow_flag <= 1'b0;
            overflow_flag  <= 1'b0;
        end else begin
            underflow_flag <= (last_cycle && fifo_empty) || (underflow_flag && !flag_clr);
            overflow_flag  <= (push_valid && fifo_full)  || (overflow_flag  && !flag_clr);
        end
    end

    AST_UFL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_flag && !flag_clr) |=> underflow_flag);                     // R8
    AST_UFL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (last_cycle && fifo_empty) |=> underflow_flag);                        // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!underflow_flag && !overflow_flag));                       // R9
endmodule

// File: tb/stream_reg_port_tb_top.sv
// Bench: directed scenarios run against a start-mode copy and a
// counter-mode copy of the block, both fed the same stimulus.
module stream_reg_port_tb_top;
    import srp_pkg::*;
    localparam int DW = 16;
    localparam int DP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_rd = 1'b0, bus_start = 1'b0;
    logic push_valid = 1'b0, flag_clr = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic [DW-1:0] rd_s, rd_c;
    logic uf_s, of_s, uf_c, of_c;

    int n_chk = 0, n_bad = 0;
    logic [DW-1:0] model[$];

    always #2.5 clk = ~clk;  // 200 MHz

    stream_reg_port #(.DATA_W(DW), .DEPTH(DP), .MODE(SRP_MODE_START)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
        .bus_start(bus_start), .bus_rdata(rd_s), .push_valid(push_valid),
        .push_data(push_data), .flag_clr(flag_clr),
        .underflow_flag(uf_s), .overflow_flag(of_s));

    stream_reg_port #(.DATA_W(DW), .DEPTH(DP), .MODE(SRP_MODE_COUNT)) dut_cnt_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
        .bus_start(bus_start), .bus_rdata(rd_c), .push_valid(push_valid),
        .push_data(push_data), .flag_clr(flag_clr),
        .underflow_flag(uf_c), .overflow_flag(of_c));

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_flags(string req, logic uf, logic of);
        check({req, " underflow start"}, DW'(uf_s), DW'(uf));
        check({req, " underflow count"}, DW'(uf_c), DW'(uf));
        check({req, " overflow start"},  DW'(of_s), DW'(of));
        check({req, " overflow count"},  DW'(of_c), DW'(of));
    endtask

    // Push one word; called and returning just after a falling edge.
    task automatic push_word(logic [DW-1:0] v);
        push_valid = 1'b1;
        push_data  = v;
        @(negedge clk);
        push_valid = 1'b0;
        if (model.size() < DP) model.push_back(v);
    endtask

    // One two-cycle read; strobes are left high for back-to-back use.
    task automatic read_xfer(string req);
        logic [DW-1:0] exp;
        exp = (model.size() == 0) ? '0 : model[0];
        bus_sel = 1'b1; bus_rd = 1'b1; bus_start = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
        check({req, " rdata start"}, rd_s, exp);
        check({req, " rdata count"}, rd_c, exp);
        @(negedge clk);
        if (model.size() != 0) void'(model.pop_front());
    endtask

    task automatic idle(int n);
        bus_sel = 1'b0; bus_rd = 1'b0; bus_start = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model.delete();
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        check("R9 rdata start after reset", rd_s, '0);
        check("R1 rdata count after reset", rd_c, '0);
        check_flags("R9 reset", 1'b0, 1'b0);
    endtask

    task automatic t_back_to_back();
        push_word(16'hA001); push_word(16'hB002); push_word(16'hC003);
        read_xfer("R2 b2b #1");
        read_xfer("R2 b2b #2");
        read_xfer("R5 b2b #3");
        idle(1);
        check("R1 empty after drain", rd_s, '0);
        check_flags("R2 no spurious", 1'b0, 1'b0);
    endtask

    task automatic t_idle_hold();
        push_word(16'h1D1D);
        idle(3);
        bus_sel = 1'b1;
        repeat (3) @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b1;
        repeat (2) @(negedge clk);
        read_xfer("R4 head kept while not strobed");
        idle(1);
    endtask

    task automatic t_underflow();
        read_xfer("R7 empty read gives zero");
        idle(1);
        check_flags("R7 underflow set", 1'b1, 1'b0);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        check_flags("R8 cleared", 1'b0, 1'b0);
        flag_clr = 1'b1;
        read_xfer("R8 set-wins read");
        flag_clr = 1'b0;
        idle(1);
        check_flags("R8 set wins over clear", 1'b1, 1'b0);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic t_overflow();
        for (int i = 0; i < DP + 1; i++) push_word(DW'(16'h5000 + i));
        check_flags("R6 overflow set", 1'b0, 1'b1);
        for (int i = 0; i < DP; i++) read_xfer("R6 order kept after drop");
        read_xfer("R6 fifth push dropped");
        idle(1);
        check_flags("R6 both flags", 1'b1, 1'b1);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        check_flags("R8 both cleared", 1'b0, 1'b0);
    endtask

    task automatic t_reset_mid();
        push_word(16'h7777); push_word(16'h8888);
        check("R5 head visible", rd_s, 16'h7777);
        do_reset();
        check("R9 fifo emptied start", rd_s, '0);
        check("R9 fifo emptied count", rd_c, '0);
    endtask

    // Strobes held high with no start pulse: only counter mode pops.
    task automatic t_mode_split();
        push_word(16'hE0E0); push_word(16'hF1F1);
        bus_sel = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        check("R3 count cycle0", rd_c, 16'hE0E0);
        @(negedge clk);
        check("R3 count next word", rd_c, 16'hF1F1);
        check("R3 start holds head", rd_s, 16'hE0E0);
        repeat (2) @(negedge clk);
        idle(1);
        check("R3 count drained", rd_c, '0);
        check("R3 start unchanged", rd_s, 16'hE0E0);
        check("R3 start no underflow", DW'(uf_s), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_back_to_back();
        t_idle_hold();
        t_underflow();
        t_overflow();
        t_reset_mid();
        t_mode_split();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule